// File: doc/BRIEF.md
# ADC Conversion Request Sequencer

This block decides when a single shared 12-bit converter samples the supply voltage and when it samples the sense current. A bus-side command write loads a five-bit mode word. For each channel the word can select free-running conversion, a single conversion that clears its own request bit when it completes, or nothing. A fifth bit picks the voltage attenuation range and is passed on to the converter. An asynchronous convert pin goes through a two-flop synchroniser. Its rising edge re-arms a single conversion of the channels named by the most recent command that selected any channel.

For each conversion the sequencer raises a one-cycle start strobe together with a channel select. It waits at least a parameterised number of clock cycles, then takes the converter's data on the first cycle in which done is also high. Results first go into staging registers. They move into the readable holding registers, and the per-channel valid flags are set, in a single commit step. That commit waits while the bus interface reports a read in progress. When both channels are requested, voltage is converted first and current second, and both results are committed together. The bus interface takes a refuse flag from the block: a read is refused while any single-shot request is still outstanding, and is otherwise accepted with whatever the holding registers contain. Before the first result that is zero.

Top module: `conv_seq`

## Requirements
- R1: After reset the mode word, both holding registers, both valid flags, the start strobe, the busy flag and the refuse flag are all zero.
- R2: Mode word bits are: bit 0 free-running voltage, bit 1 single voltage, bit 2 free-running current, bit 3 single current, bit 4 voltage range. A single bit clears itself in the cycle its results are committed, and no other event clears it except a command write.
- R3: `rd_nack` is high exactly while bit 1 or bit 3 of the mode word is set. With only free-running bits set, reads are accepted, and a holding register that has never been committed reads as zero.
- R4: When both channels are requested in one sequence, the voltage start (`adc_chan`=0) comes before the current start (`adc_chan`=1). The voltage holding register does not change until the current conversion has also finished.
- R5: A result is taken no earlier than CONV_CYCLES clock cycles after its start strobe, and only in a cycle where `adc_done` is high. The holding register then equals the data presented for that start.
- R6: A synchronised rising edge on `conv_pin` while the sequencer is idle sets the single bits of the channels chosen by the last command that selected a channel. A rising edge while a sequence runs is ignored and is not queued.
- R7: While `rd_busy` is high, the holding registers and valid flags do not change. A finished sequence waits and commits once `rd_busy` is low.
- R8: While a free-running bit is set, a new sequence starts after every commit, so the holding register keeps tracking fresh results.
- R9: When a command write and a commit fall in the same cycle, the mode word afterwards equals the written value, so a newly written single request survives.
- R10: Bit 4 of the mode word drives `adc_range`. A write with no channel bits set starts no conversion.
- R11: `adc_start` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | One-cycle mode word write strobe |
| cmd_data | input | 5 | Mode word value written on `cmd_wr` |
| conv_pin | input | 1 | Asynchronous external convert request |
| rd_busy | input | 1 | Bus read in progress; holds off result commits |
| adc_done | input | 1 | Converter has data ready |
| adc_data | input | DW | Converter result |
| adc_start | output | 1 | One-cycle conversion start strobe |
| adc_chan | output | 1 | Channel for the current conversion: 0 voltage, 1 current |
| adc_range | output | 1 | Voltage attenuation range select |
| mode_q | output | 5 | Stored mode word |
| volt_res | output | DW | Voltage holding register |
| curr_res | output | DW | Current holding register |
| volt_valid | output | 1 | Voltage result has been committed at least once |
| curr_valid | output | 1 | Current result has been committed at least once |
| seq_busy | output | 1 | A sequence is running or waiting to commit |
| rd_nack | output | 1 | A read now must be refused |

## Verification
A command write and a result commit can land in the same clock edge. Both then update the mode word: the commit wants to clear the finished single bits, and the write replaces the whole word. The bench provokes this by holding `rd_busy` high until a single-shot current sequence is parked at its commit. It then drops `rd_busy` and pulses `cmd_wr` with the same single-shot request in one cycle. It judges the outcome by three things: the mode word still carries the request, the holding register has taken the first result, and exactly one further conversion follows. Randomised read-busy pulses across many single-shot runs also place commits next to writes.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

  localparam int NCH     = 2;
  localparam int CH_V    = 0;
  localparam int CH_I    = 1;
  localparam int CMD_W   = 5;
  localparam int B_VCONT = 0;
  localparam int B_VONCE = 1;
  localparam int B_ICONT = 2;
  localparam int B_IONCE = 3;
  localparam int B_RANGE = 4;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_WAIT,
    ST_COMMIT
  } seq_state_t;

  // Channels a mode word asks for (free-running or single).
  function automatic logic [NCH-1:0] want_mask(input logic [CMD_W-1:0] m);
    logic [NCH-1:0] r;
    r[CH_V] = m[B_VCONT] | m[B_VONCE];
    r[CH_I] = m[B_ICONT] | m[B_IONCE];
    return r;
  endfunction

  // Channels with an outstanding single request.
  function automatic logic [NCH-1:0] once_mask(input logic [CMD_W-1:0] m);
    logic [NCH-1:0] r;
    r[CH_V] = m[B_VONCE];
    r[CH_I] = m[B_IONCE];
    return r;
  endfunction

  // Mode word bits holding the single requests of a channel mask.
  function automatic logic [CMD_W-1:0] once_bits(input logic [NCH-1:0] ch);
    logic [CMD_W-1:0] r;
    r = '0;
    r[B_VONCE] = ch[CH_V];
    r[B_IONCE] = ch[CH_I];
    return r;
  endfunction

endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[STAGES-1:0], async_in};
  end

  // Rising edge seen between the last synchroniser stage and the one after.
  assign rise_o = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/cs_cmd_reg.sv
module cs_cmd_reg
  import conv_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             pin_rise,
  input  logic             eng_idle,
  input  logic [NCH-1:0]   done_mask,
  output logic [CMD_W-1:0] mode_q
);
  logic [NCH-1:0] sel_q;
  logic           pin_arm;

  assign pin_arm = pin_rise & eng_idle;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else if (cmd_wr) begin
      mode_q <= cmd_data;
      if (|want_mask(cmd_data)) sel_q <= want_mask(cmd_data);
    end else begin
      mode_q <= (mode_q & ~once_bits(done_mask))
              | (pin_arm ? once_bits(sel_q) : '0);
    end
  end
endmodule

// File: rtl/cs_engine.sv
module cs_engine
  import conv_seq_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 15000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CMD_W-1:0]        mode_q,
  input  logic                    rd_busy,
  input  logic                    adc_done,
  input  logic [DW-1:0]           adc_data,
  output logic                    adc_start,
  output logic                    adc_chan,
  output logic                    eng_idle,
  output logic                    commit_evt,
  output logic                    cap_evt,
  output logic [NCH-1:0]          snap_q,
  output logic [NCH-1:0][DW-1:0]  stage_q
);
  localparam int TW = $clog2(CONV_CYCLES + 1);
  localparam logic [TW-1:0] TMAX = TW'(CONV_CYCLES);

  seq_state_t     st;
  logic [TW-1:0]  tmr;
  logic           cur;
  logic           tmr_done;
  logic [NCH-1:0] want;

  assign want       = want_mask(mode_q);
  assign tmr_done   = (tmr >= TMAX);
  assign adc_start  = (st == ST_START);
  assign adc_chan   = cur;
  assign eng_idle   = (st == ST_IDLE);
  assign cap_evt    = (st == ST_WAIT) & tmr_done & adc_done;
  assign commit_evt = (st == ST_COMMIT) & ~rd_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      tmr     <= '0;
      cur     <= 1'b0;
      snap_q  <= '0;
      stage_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (|want) begin
          snap_q <= want;
          cur    <= ~want[CH_V];
          st     <= ST_START;
        end
        ST_START: begin
          tmr <= TW'(1);
          st  <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!tmr_done) tmr <= tmr + TW'(1);
          if (cap_evt) begin
            stage_q[cur] <= adc_data;
            if (!cur && snap_q[CH_I]) begin
              cur <= 1'b1;
              st  <= ST_START;
            end else begin
              st  <= ST_COMMIT;
            end
          end
        end
        ST_COMMIT: if (!rd_busy) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cs_hold.sv
module cs_hold
  import conv_seq_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   commit_evt,
  input  logic [NCH-1:0]         snap_q,
  input  logic [NCH-1:0][DW-1:0] stage_q,
  output logic [NCH-1:0][DW-1:0] res_q,
  output logic [NCH-1:0]         valid_q
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[c]   <= '0;
        valid_q[c] <= 1'b0;
      end else if (commit_evt && snap_q[c]) begin
        res_q[c]   <= stage_q[c];
        valid_q[c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import conv_seq_pkg::*;
#(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 15000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_data,
  input  logic             conv_pin,
  input  logic             rd_busy,
  input  logic             adc_done,
  input  logic [DW-1:0]    adc_data,
  output logic             adc_start,
  output logic             adc_chan,
  output logic             adc_range,
  output logic [CMD_W-1:0] mode_q,
  output logic [DW-1:0]    volt_res,
  output logic [DW-1:0]    curr_res,
  output logic             volt_valid,
  output logic             curr_valid,
  output logic             seq_busy,
  output logic             rd_nack
);
  logic                   pin_rise;
  logic                   eng_idle;
  logic                   commit_evt;
  logic                   cap_evt;
  logic [NCH-1:0]         snap_q;
  logic [NCH-1:0]         done_mask;
  logic [NCH-1:0][DW-1:0] stage_q;
  logic [NCH-1:0][DW-1:0] res_q;
  logic [NCH-1:0]         valid_q;

  cs_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(conv_pin), .rise_o(pin_rise)
  );

  assign done_mask = commit_evt ? snap_q : '0;

  cs_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .pin_rise(pin_rise), .eng_idle(eng_idle), .done_mask(done_mask),
    .mode_q(mode_q)
  );

  cs_engine #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .rd_busy(rd_busy),
    .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
    .adc_chan(adc_chan), .eng_idle(eng_idle), .commit_evt(commit_evt),
    .cap_evt(cap_evt), .snap_q(snap_q), .stage_q(stage_q)
  );

  cs_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .commit_evt(commit_evt), .snap_q(snap_q),
    .stage_q(stage_q), .res_q(res_q), .valid_q(valid_q)
  );

  assign volt_res   = res_q[CH_V];
  assign curr_res   = res_q[CH_I];
  assign volt_valid = valid_q[CH_V];
  assign curr_valid = valid_q[CH_I];
  assign adc_range  = mode_q[B_RANGE];
  assign seq_busy   = ~eng_idle;
  assign rd_nack    = |once_mask(mode_q);
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk #(
  parameter int DW          = 12,
  parameter int CONV_CYCLES = 15000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          adc_start,
  input logic          adc_done,
  input logic          rd_busy,
  input logic [DW-1:0] volt_res,
  input logic [DW-1:0] curr_res,
  input logic          volt_valid,
  input logic          curr_valid,
  input logic [4:0]    mode_q,
  input logic          cmd_wr,
  input logic [4:0]    cmd_data,
  input logic          cap_evt,
  input logic          commit_evt,
  input logic          pin_rise,
  input logic          eng_idle
);
  int unsigned since_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_start <= 0;
    else if (adc_start)                  since_start <= 0;
    else if (since_start < CONV_CYCLES)  since_start <= since_start + 1;
  end

  // R11
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> !adc_start);

  // R5
  conv_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (adc_done && (since_start + 1 >= CONV_CYCLES)));

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> ($stable(volt_res) && $stable(curr_res)
                 && $stable(volt_valid) && $stable(curr_valid)));

  // R2
  vonce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[1]) |-> ($past(cmd_wr) || $past(commit_evt)));

  // R2
  ionce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_q[3]) |-> ($past(cmd_wr) || $past(commit_evt)));

  // R6
  pin_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rise && !eng_idle && !cmd_wr && !commit_evt) |=> $stable(mode_q));

  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && commit_evt) |=> (mode_q == $past(cmd_data)));
endmodule

bind conv_seq conv_seq_chk #(.DW(DW), .CONV_CYCLES(CONV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .adc_start(adc_start), .adc_done(adc_done),
  .rd_busy(rd_busy), .volt_res(volt_res), .curr_res(curr_res),
  .volt_valid(volt_valid), .curr_valid(curr_valid), .mode_q(mode_q),
  .cmd_wr(cmd_wr), .cmd_data(cmd_data), .cap_evt(cap_evt),
  .commit_evt(commit_evt), .pin_rise(pin_rise), .eng_idle(eng_idle)
);

// File: tb/test_conv_seq.sv
module test_conv_seq;
  localparam int DW   = 12;
  localparam int CONV = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_wr = 1'b0;
  logic [4:0]    cmd_data = '0;
  logic          conv_pin = 1'b0;
  logic          rd_busy = 1'b0;
  logic          adc_done = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic          adc_start, adc_chan, adc_range;
  logic [4:0]    mode_q;
  logic [DW-1:0] volt_res, curr_res;
  logic          volt_valid, curr_valid, seq_busy, rd_nack;

  int checks = 0;
  int fails  = 0;
  int n_starts = 0;
  int dly = 0;
  logic [DW-1:0] last_data [2];
  logic          start_ch  [64];
  logic [DW-1:0] start_hv  [64];

  always #5 clk = ~clk;

  conv_seq #(.DW(DW), .CONV_CYCLES(CONV)) i_conv_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .conv_pin(conv_pin), .rd_busy(rd_busy), .adc_done(adc_done),
    .adc_data(adc_data), .adc_start(adc_start), .adc_chan(adc_chan),
    .adc_range(adc_range), .mode_q(mode_q), .volt_res(volt_res),
    .curr_res(curr_res), .volt_valid(volt_valid), .curr_valid(curr_valid),
    .seq_busy(seq_busy), .rd_nack(rd_nack)
  );

  // Converter model: fresh data and a random done delay per start.
  function automatic logic [DW-1:0] pick_data();
    return DW'($urandom_range(0, (1 << DW) - 1));
  endfunction

  initial begin
    last_data[0] = '0;
    last_data[1] = '0;
    forever begin
      @(negedge clk);
      if (adc_start) begin
        adc_done = 1'b0;
        adc_data = pick_data();
        last_data[adc_chan] = adc_data;
        start_ch[n_starts % 64] = adc_chan;
        start_hv[n_starts % 64] = volt_res;
        n_starts++;
        dly = $urandom_range(1, 2 * CONV);
      end else if (!adc_done) begin
        if (dly > 1) dly--;
        else adc_done = 1'b1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] d);
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_data = d;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  task automatic wait_idle(input bit rand_busy);
    int n = 0;
    while (!(seq_busy == 1'b0 && rd_nack == 1'b0) && n < 3000) begin
      @(negedge clk);
      if (rand_busy) rd_busy = ($urandom_range(0, 3) == 0);
      n++;
    end
    rd_busy = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] pv;
    int base;
    void'($urandom(32'h5eed_0c0d));
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 mode", int'(mode_q), 0);
    chk("R1 volt", int'(volt_res), 0);
    chk("R1 curr", int'(curr_res), 0);
    chk("R1 valid", int'({volt_valid, curr_valid}), 0);
    chk("R1 busy/nack/start", int'({seq_busy, rd_nack, adc_start}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: free-running current, read before first result
    wr(5'h04);
    chk("R3 cont ack", int'(rd_nack), 0);
    chk("R3 zero data", int'(curr_res), 0);
    repeat (200) @(negedge clk);
    // R8 keeps restarting
    chk("R8 restarts", int'(n_starts >= 4), 1);
    chk("R8 current only", int'(start_ch[0] | start_ch[1]), 1);
    chk("R8 valid", int'(curr_valid), 1);
    wr(5'h00);
    wait_idle(1'b0);
    chk("R5 cont data", int'(curr_res), int'(last_data[1]));

    // R2/R3: single voltage
    n_starts = 0;
    wr(5'h02);
    chk("R3 nack pending", int'(rd_nack), 1);
    chk("R2 bit set", int'(mode_q[1]), 1);
    wait_idle(1'b0);
    chk("R2 self clear", int'(mode_q), 0);
    chk("R5 volt data", int'(volt_res), int'(last_data[0]));
    chk("R2 one start", n_starts, 1);
    chk("R2 volt valid", int'(volt_valid), 1);

    // R4: both channels, ordering and joint commit
    n_starts = 0;
    pv = volt_res;
    wr(5'h0A);
    wait_idle(1'b0);
    chk("R4 two starts", n_starts, 2);
    chk("R4 volt first", int'(start_ch[0]), 0);
    chk("R4 curr second", int'(start_ch[1]), 1);
    chk("R4 volt held", int'(start_hv[1]), int'(pv));
    chk("R4 volt data", int'(volt_res), int'(last_data[0]));
    chk("R4 curr data", int'(curr_res), int'(last_data[1]));

    // R10: range bit only
    n_starts = 0;
    wr(5'h10);
    repeat (20) @(negedge clk);
    chk("R10 range", int'(adc_range), 1);
    chk("R10 no start", n_starts, 0);
    chk("R10 idle", int'(seq_busy), 0);

    // R6: pin re-arms last selection (both), second edge while busy ignored
    n_starts = 0;
    @(negedge clk);
    conv_pin = 1'b1;
    while (!seq_busy) @(negedge clk);
    conv_pin = 1'b0;
    repeat (3) @(negedge clk);
    conv_pin = 1'b1;
    repeat (3) @(negedge clk);
    conv_pin = 1'b0;
    wait_idle(1'b0);
    repeat (20) @(negedge clk);
    chk("R6 pin starts", n_starts, 2);
    chk("R6 pin data", int'(curr_res), int'(last_data[1]));
    chk("R6 bits cleared", int'(mode_q), 5'h10);
    wr(5'h00);

    // R7 + R9: commit held by rd_busy, then write lands on the commit edge
    n_starts = 0;
    pv = curr_res;
    wr(5'h08);
    rd_busy = 1'b1;
    repeat (60) @(negedge clk);
    chk("R7 held data", int'(curr_res), int'(pv));
    chk("R7 still busy", int'({seq_busy, rd_nack}), 3);
    cmd_wr = 1'b1;
    cmd_data = 5'h08;
    rd_busy = 1'b0;
    @(negedge clk);
    cmd_wr = 1'b0;
    chk("R9 write wins", int'(mode_q), 5'h08);
    chk("R7 committed", int'(curr_res), int'(last_data[1]));
    chk("R9 nack kept", int'(rd_nack), 1);
    base = n_starts;
    wait_idle(1'b0);
    chk("R9 second run", n_starts, base + 1);
    chk("R9 data", int'(curr_res), int'(last_data[1]));

    // Random single-shot runs with random read-busy pulses
    for (int k = 0; k < 30; k++) begin
      logic [4:0] c;
      case ($urandom_range(0, 2))
        0:       c = 5'h02;
        1:       c = 5'h08;
        default: c = 5'h0A;
      endcase
      wr(c);
      chk("R3 rand nack", int'(rd_nack), 1);
      wait_idle(1'b1);
      chk("R2 rand clear", int'(mode_q), 0);
      if (c[1]) chk("R5 rand volt", int'(volt_res), int'(last_data[0]));
      if (c[3]) chk("R5 rand curr", int'(curr_res), int'(last_data[1]));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule